// File: doc/BRIEF.md
# Control Endpoint Interrupt Status Register

This block holds the interrupt flags of a USB control endpoint. The endpoint's transaction logic reports each event with a one-cycle strobe. The strobe raises the matching flag on the next clock edge. Software reads the flags through a small word-addressed register port and clears a flag by writing 1 to its bit. Writing 0 to a bit leaves that bit as it is.

The arrival of a SETUP token opens a new control transfer. It raises the token flag and, in the same cycle, clears every other flag. Only software can clear the token flag.

A length checker watches each received SETUP data payload. It raises a data error flag when the length is not exactly eight bytes.

An enable register of the same width selects which flags can interrupt. The interrupt line is a registered OR of the enabled flags.

Top module: `ep0_irq_status`

## Requirements
- R1: After reset the status word and the enable word both read 0 and `irq_o` is 0.
- R2: Each event strobe sets its flag on the next clock edge. The bit positions are: 0 OUT token, 1 OUT data, 2 OUT overrun, 3 IN token, 4 IN transmitted, 5 NAK sent, 6 STALL sent, 7 transaction error, 8 SETUP token, 9 SETUP data, 10 SETUP data error, 11 zero-length data.
- R3: A write to the status word (address 0) clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: A SETUP token strobe sets bit 8. In the same edge it clears bits 11:9 and 7:0, unless an event sets one of those bits in that same cycle.
- R5: Bit 8 is cleared only by writing 1 to it. A further SETUP token, or a write of 0 to that bit, leaves it set.
- R6: When an event and a write-1 clear hit the same flag in one cycle, the flag ends up set.
- R7: When an event and a SETUP token clear hit the same flag in one cycle, the flag ends up set.
- R8: A SETUP data strobe always sets bit 9. It also sets bit 10 when `setup_len` is not 8.
- R9: Bits 31:12 of both registers read 0. Addresses 2 and 3 read 0, and writes to them change nothing.
- R10: `irq_o` equals the OR of (flags AND enable) as they stood one cycle earlier.
- R11: A write to address 1 loads bits 11:0 of the data into the enable word, which reads back the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_out_tok | input | 1 | OUT token received strobe |
| ev_out_data | input | 1 | OUT data received strobe |
| ev_out_ovr | input | 1 | OUT data overrun strobe |
| ev_in_tok | input | 1 | IN token received strobe |
| ev_in_done | input | 1 | IN data transmitted strobe |
| ev_nak | input | 1 | NAK handshake sent strobe |
| ev_stall | input | 1 | STALL handshake sent strobe |
| ev_xact_err | input | 1 | Transaction error strobe |
| ev_setup_tok | input | 1 | SETUP token received strobe |
| ev_setup_data | input | 1 | SETUP data payload received strobe |
| setup_len | input | LEN_W (7) | Byte count of the SETUP payload, valid with `ev_setup_data` |
| ev_zero_len | input | 1 | Zero-length data packet received strobe |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write when 1 (with `bus_sel`) |
| bus_addr | input | ADDR_W (2) | Word address: 0 status, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check several properties. Each event strobe must leave its flag set, and a lone SETUP token must leave exactly bit 8 set. The SETUP token flag must survive anything but a write of 1 to it. The interrupt line must follow the masked flags one cycle late, and the reserved read bits must stay 0.

Some properties can only be shown by the bench's scenarios. These are the exact outcome of set and clear collisions, the write-0 no-effect rule, the split between the length-8 and other-length payloads, and address decoding. The bench drives long mixed random sequences, so these are compared against a reference model.

// File: rtl/ep0_irq_pkg.sv
// Package: shared flag positions and widths for the endpoint interrupt block.
// Assumes: twelve implemented flags, all other bits of the 32-bit word reserved.
package ep0_irq_pkg;
    localparam int NFLAG  = 12;
    localparam int DATA_W = 32;

    localparam int B_OUT_TOK   = 0;
    localparam int B_OUT_DATA  = 1;
    localparam int B_OUT_OVR   = 2;
    localparam int B_IN_TOK    = 3;
    localparam int B_IN_DONE   = 4;
    localparam int B_NAK       = 5;
    localparam int B_STALL     = 6;
    localparam int B_XACT_ERR  = 7;
    localparam int B_SETUP_TOK = 8;
    localparam int B_SETUP_DAT = 9;
    localparam int B_SETUP_ERR = 10;
    localparam int B_ZERO_LEN  = 11;

    typedef logic [NFLAG-1:0] flag_vec_t;

    // Flags that a SETUP token never clears
    localparam flag_vec_t STICKY_MASK = flag_vec_t'(1) << B_SETUP_TOK;
endpackage

// File: rtl/ep0_setup_len_check.sv
// Module: compares the byte count of a received SETUP payload with the
// expected size and emits a one-cycle error strobe on mismatch.
// Assumes: setup_len is valid whenever data_stb is high.
module ep0_setup_len_check #(
    parameter int LEN_W     = 7,
    parameter int SETUP_LEN = 8
) (
    input  logic             data_stb,
    input  logic [LEN_W-1:0] setup_len,
    output logic             len_err_stb
);
    localparam logic [LEN_W-1:0] EXP_LEN = LEN_W'(SETUP_LEN);

    // Flag a payload whose length differs from the expected count
    always_comb begin
        len_err_stb = data_stb && (setup_len != EXP_LEN);
    end
endmodule

// File: rtl/ep0_flag_cell.sv
// Module: one interrupt flag with set-dominant priority.
// A set strobe beats every clear. The hardware clear is ignored when STICKY = 1.
// Assumes: all inputs are synchronous to clk.
module ep0_flag_cell #(
    parameter bit STICKY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stb,
    input  logic sw_clr,
    input  logic hw_clr,
    output logic q
);
    logic clr_any;

    // Combine the clear sources permitted for this flag
    always_comb begin
        clr_any = sw_clr || (!STICKY && hw_clr);
    end

    // Flag storage: set wins, then clear, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set_stb)
            q <= 1'b1;
        else if (clr_any)
            q <= 1'b0;
    end
endmodule

// File: rtl/ep0_flag_bank.sv
// Module: array of flag cells. Cells named in STICKY_MASK ignore the SETUP clear.
// Assumes: set, write-1-clear and SETUP clear vectors are one-cycle pulses.
module ep0_flag_bank
    import ep0_irq_pkg::*;
#(
    parameter int        N      = NFLAG,
    parameter flag_vec_t STICKY = STICKY_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] w1c_vec,
    input  logic         setup_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        ep0_flag_cell #(.STICKY(STICKY[i])) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_vec[i]),
            .sw_clr  (w1c_vec[i]),
            .hw_clr  (setup_clr),
            .q       (flags[i])
        );
    end
endmodule

// File: rtl/ep0_reg_port.sv
// Module: word-addressed register port. It decodes write-1-clear strobes for
// the status word, holds the enable word and muxes read data.
// Assumes: a write takes effect on the edge where bus_sel and bus_wr are high.
// Read data is combinational and does not depend on bus_sel.
module ep0_reg_port
    import ep0_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int N      = NFLAG,
    parameter int DW     = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [N-1:0]      flags,
    output logic [N-1:0]      w1c_vec,
    output logic [N-1:0]      en_q,
    output logic [DW-1:0]     bus_rdata
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);

    logic wr_stat, wr_en;

    // Decode the write target
    always_comb begin
        wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
        wr_en   = bus_sel && bus_wr && (bus_addr == A_EN);
        w1c_vec = wr_stat ? bus_wdata[N-1:0] : '0;
    end

    // Enable word storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= bus_wdata[N-1:0];
    end

    // Read mux; reserved bits and unused addresses return zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STAT:  bus_rdata[N-1:0] = flags;
            A_EN:    bus_rdata[N-1:0] = en_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ep0_irq_status.sv
// Module: control endpoint interrupt status block (top).
// It gathers event strobes into a set vector, drives the flag bank, the
// register port and the registered interrupt line.
// Assumes: synchronous active-low reset; every event input is a one-cycle strobe.
module ep0_irq_status
    import ep0_irq_pkg::*;
#(
    parameter int LEN_W     = 7,
    parameter int SETUP_LEN = 8,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_out_tok,
    input  logic              ev_out_data,
    input  logic              ev_out_ovr,
    input  logic              ev_in_tok,
    input  logic              ev_in_done,
    input  logic              ev_nak,
    input  logic              ev_stall,
    input  logic              ev_xact_err,
    input  logic              ev_setup_tok,
    input  logic              ev_setup_data,
    input  logic [LEN_W-1:0]  setup_len,
    input  logic              ev_zero_len,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    logic      len_err_stb;
    flag_vec_t set_vec, w1c_vec, flags_q, en_q;
    logic      irq_q;

    ep0_setup_len_check #(.LEN_W(LEN_W), .SETUP_LEN(SETUP_LEN)) u_len (
        .data_stb    (ev_setup_data),
        .setup_len   (setup_len),
        .len_err_stb (len_err_stb)
    );

    // Place each event strobe at its flag position
    always_comb begin
        set_vec              = '0;
        set_vec[B_OUT_TOK]   = ev_out_tok;
        set_vec[B_OUT_DATA]  = ev_out_data;
        set_vec[B_OUT_OVR]   = ev_out_ovr;
        set_vec[B_IN_TOK]    = ev_in_tok;
        set_vec[B_IN_DONE]   = ev_in_done;
        set_vec[B_NAK]       = ev_nak;
        set_vec[B_STALL]     = ev_stall;
        set_vec[B_XACT_ERR]  = ev_xact_err;
        set_vec[B_SETUP_TOK] = ev_setup_tok;
        set_vec[B_SETUP_DAT] = ev_setup_data;
        set_vec[B_SETUP_ERR] = len_err_stb;
        set_vec[B_ZERO_LEN]  = ev_zero_len;
    end

    ep0_flag_bank #(.N(NFLAG), .STICKY(STICKY_MASK)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .w1c_vec   (w1c_vec),
        .setup_clr (ev_setup_tok),
        .flags     (flags_q)
    );

    ep0_reg_port #(.ADDR_W(ADDR_W), .N(NFLAG), .DW(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags_q),
        .w1c_vec   (w1c_vec),
        .en_q      (en_q),
        .bus_rdata (bus_rdata)
    );

    // Register the masked OR so the line moves one cycle after the flags
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(flags_q & en_q);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/ep0_irq_status_chk.sv
// Checker: cycle properties of the endpoint interrupt block, bound to the top.
module ep0_irq_status_chk #(
    parameter int LEN_W     = 7,
    parameter int SETUP_LEN = 8,
    parameter int ADDR_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_out_tok,
    input logic              ev_out_data,
    input logic              ev_out_ovr,
    input logic              ev_in_tok,
    input logic              ev_in_done,
    input logic              ev_nak,
    input logic              ev_stall,
    input logic              ev_xact_err,
    input logic              ev_setup_tok,
    input logic              ev_setup_data,
    input logic [LEN_W-1:0]  setup_len,
    input logic              ev_zero_len,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_o,
    input logic [11:0]       flags_q,
    input logic [11:0]       en_q
);
    logic others_quiet, clr8_wr;
    always_comb begin
        others_quiet = !(ev_out_tok || ev_out_data || ev_out_ovr || ev_in_tok ||
                         ev_in_done || ev_nak || ev_stall || ev_xact_err ||
                         ev_setup_data || ev_zero_len);
        clr8_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(0)) && bus_wdata[8];
    end

    // R9: reserved read bits stay zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:12] == 20'h0);

    // R2: an event always leaves its flag set
    a_r2_out_tok_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_out_tok |=> flags_q[0]);
    a_r2_nak_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nak |=> flags_q[5]);

    // R4: a lone SETUP token leaves only bit 8 set
    a_r4_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup_tok && others_quiet) |=> (flags_q == 12'h100));

    // R5: the token flag survives anything but a write of 1
    a_r5_token_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[8] && !clr8_wr) |=> flags_q[8]);

    // R8: a payload of the wrong length raises the error flag
    a_r8_len_err: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup_data && setup_len != LEN_W'(SETUP_LEN)) |=> (flags_q[10] && flags_q[9]));

    // R10: interrupt follows masked flags one cycle later
    a_r10_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(flags_q & en_q))));
endmodule

bind ep0_irq_status ep0_irq_status_chk #(
    .LEN_W(LEN_W), .SETUP_LEN(SETUP_LEN), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_ep0_irq_status.sv
// Bench: a reference model with fixed-seed random stimulus plus directed corner cases.
module tb_ep0_irq_status;
    logic clk = 1'b0;
    logic rst_n;
    logic ev_out_tok, ev_out_data, ev_out_ovr, ev_in_tok, ev_in_done;
    logic ev_nak, ev_stall, ev_xact_err, ev_setup_tok, ev_setup_data, ev_zero_len;
    logic [6:0]  setup_len;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [11:0] mf, men;
    logic        mirq;

    always #10 clk = ~clk;

    ep0_irq_status dut (.*);

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {20'h0, mf};
            2'd1:    return {20'h0, men};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [11:0] set_vec_now();
        logic [11:0] s;
        s = {ev_zero_len, ev_setup_data && (setup_len != 7'd8), ev_setup_data,
             ev_setup_tok, ev_xact_err, ev_stall, ev_nak, ev_in_done,
             ev_in_tok, ev_out_ovr, ev_out_data, ev_out_tok};
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {ev_out_tok, ev_out_data, ev_out_ovr, ev_in_tok, ev_in_done, ev_nak,
         ev_stall, ev_xact_err, ev_setup_tok, ev_setup_data, ev_zero_len} = '0;
        setup_len = 7'd8;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    // Check outputs for the current state, then advance the model and the design one edge
    task automatic step();
        logic [11:0] s, w;
        #1;
        check("R2/R3 status read", bus_rdata, exp_read(bus_addr));
        check("R10 irq", {31'h0, irq_o}, {31'h0, mirq});
        s = set_vec_now();
        w = (bus_sel && bus_wr && bus_addr == 2'd0) ? bus_wdata[11:0] : 12'h0;
        @(posedge clk);
        mirq = |(mf & men);
        for (int i = 0; i < 12; i++) begin
            if (s[i]) mf[i] = 1'b1;
            else if (w[i] || (ev_setup_tok && i != 8)) mf[i] = 1'b0;
        end
        if (bus_sel && bus_wr && bus_addr == 2'd1) men = bus_wdata[11:0];
        @(negedge clk);
        idle();
    endtask

    task automatic peek(input string tag, input logic [1:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst_n = 1'b0; mf = '0; men = '0; mirq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        peek("R1 status", 2'd0, 32'h0);
        peek("R1 enable", 2'd1, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);

        // R11 / R9: enable write and reserved bits
        wr(2'd1, 32'hFFFF_FFFF); step();
        peek("R11 enable readback", 2'd1, 32'h0000_0FFF);
        wr(2'd2, 32'hFFFF_FFFF); step();
        peek("R9 unused address", 2'd2, 32'h0);
        peek("R9 unused address 3", 2'd3, 32'h0);
        peek("R9 enable unchanged", 2'd1, 32'h0000_0FFF);
        wr(2'd1, 32'h0); step();

        // R2 and R10: one event, irq one cycle after the flag
        wr(2'd1, 32'h1); step();
        ev_out_tok = 1'b1; step();
        peek("R2 out token flag", 2'd0, 32'h1);
        check("R10 irq not yet", {31'h0, irq_o}, 32'h0);
        step();
        check("R10 irq raised", {31'h0, irq_o}, 32'h1);

        // R3: write 0 keeps, write 1 clears
        ev_nak = 1'b1; ev_stall = 1'b1; step();
        wr(2'd0, 32'h0000_0000); step();
        peek("R3 write zero keeps", 2'd0, 32'h61);
        wr(2'd0, 32'h0000_0020); step();
        peek("R3 write one clears", 2'd0, 32'h41);

        // R6: set beats write-1 clear
        ev_stall = 1'b1; wr(2'd0, 32'h40); step();
        peek("R6 set wins over clear", 2'd0, 32'h41);

        // R7 and R4: SETUP token with a same-cycle event
        ev_xact_err = 1'b1; ev_in_tok = 1'b1; step();
        ev_setup_tok = 1'b1; ev_stall = 1'b1; step();
        peek("R7 stall survives setup clear", 2'd0, 32'h140);
        ev_setup_tok = 1'b1; step();
        peek("R4 lone setup token", 2'd0, 32'h100);

        // R5: token flag only cleared by writing 1
        ev_setup_tok = 1'b1; step();
        wr(2'd0, 32'hFFFF_FEFF); step();
        peek("R5 write zero keeps token", 2'd0, 32'h100);
        wr(2'd0, 32'h100); step();
        peek("R5 write one clears token", 2'd0, 32'h0);

        // R8: length checker
        ev_setup_data = 1'b1; setup_len = 7'd8; step();
        peek("R8 length 8 no error", 2'd0, 32'h200);
        ev_setup_data = 1'b1; setup_len = 7'd5; step();
        peek("R8 length 5 error", 2'd0, 32'h600);
        wr(2'd0, 32'hFFF); step();
        ev_setup_data = 1'b1; setup_len = 7'd0; ev_zero_len = 1'b1; step();
        peek("R8 length 0 error", 2'd0, 32'hE00);

        // Random mix checked against the model
        for (int n = 0; n < 3000; n++) begin
            ev_out_tok    = ($urandom % 6) == 0;
            ev_out_data   = ($urandom % 6) == 0;
            ev_out_ovr    = ($urandom % 8) == 0;
            ev_in_tok     = ($urandom % 6) == 0;
            ev_in_done    = ($urandom % 6) == 0;
            ev_nak        = ($urandom % 7) == 0;
            ev_stall      = ($urandom % 9) == 0;
            ev_xact_err   = ($urandom % 9) == 0;
            ev_setup_tok  = ($urandom % 12) == 0;
            ev_setup_data = ($urandom % 8) == 0;
            ev_zero_len   = ($urandom % 8) == 0;
            setup_len     = (($urandom % 2) == 0) ? 7'd8 : 7'($urandom % 16);
            bus_sel       = ($urandom % 3) == 0;
            bus_wr        = ($urandom % 2) == 0;
            bus_addr      = 2'($urandom % 4);
            bus_wdata     = $urandom;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule